// File: doc/BRIEF.md
# Byte-Serial Register Write Receiver

This block turns a narrow byte stream into parallel register writes. A source places one byte per clock on an 8-bit input. It raises a strobe together with the first byte of each command. Five more bytes follow on the next five clocks: two address bytes, then four data bytes. The block collects these six bytes and tests the 16-bit address against a base value. The test only looks at the bit positions selected by a mask. When the address matches, the block issues a write that lasts one clock. The write carries the 32-bit data and the address bits that the mask leaves free.

The block sits in front of a register bank that decodes the free address bits. It works on a single clock and uses a synchronous reset. Bytes that arrive while no command is open are ignored. A strobe that arrives in the middle of a command discards the bytes collected so far and starts a new command.

Top module: `cmd_byte_rx`

## Requirements
- R1: After reset, `wr_valid` is 0, `wr_offset` is 0 and `wr_data` is 0, and no command is open.
- R2: Byte k after the strobe byte (the strobe byte is k=0) goes into bit field [8k+7:8k] of a 48-bit frame. Address = frame[15:0], so the low address byte comes first. Data = frame[47:16], so data byte 0 is the least significant byte.
- R3: When the sixth byte of a command is sampled and the command is accepted, `wr_valid` is 1 for exactly the following clock cycle and 0 in the cycle after that.
- R4: A command is accepted when `(address & ADDR_MASK) == (BASE_ADDR & ADDR_MASK)`. The defaults are mask 0x07FF and base 0x0714.
- R5: A command whose masked address differs from the masked base produces no `wr_valid` pulse.
- R6: During an accepted write, `wr_offset` equals `address & ~ADDR_MASK`. For example, address 0x1F14 gives 0x1800 with the defaults.
- R7: A strobe while a command is open drops the partial command. The byte that arrives with that strobe becomes address-low of a new command, which then needs five further bytes.
- R8: Bytes without a strobe have no effect while no command is open. This includes bytes that follow a completed sixth byte.
- R9: `wr_offset` and `wr_data` change only on an accepted write and hold their values otherwise, including after a rejected command.
- R10: A reset during an open command discards it. The bytes that follow without a strobe produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Command byte sampled every clock |
| cmd_stb | input | 1 | Marks the first byte of a command |
| wr_valid | output | 1 | One-cycle write pulse for an accepted command |
| wr_offset | output | 16 | Address bits outside the mask for the write |
| wr_data | output | 32 | Assembled write data |

## Verification
The stimulus table covers four areas: matching and non-matching addresses, addresses that differ only in bits the mask leaves free, and data patterns whose byte order would come out scrambled if assembly were reversed. A design that compared the unmasked address would reject 0x1F14. A design that failed to restart on a mid-command strobe would merge two commands. The directed tests target four more mistakes:
- firing on bytes that arrive without a strobe;
- firing when a strobe replaces the sixth byte;
- surviving a reset during an open command;
- letting a rejected command overwrite the held data.

A design that stretched the pulse, or pulsed again on trailing bytes, is caught by a count of pulses per command.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_e;

endpackage

// File: rtl/cmd_addr_match.sv
module cmd_addr_match #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] MASK = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (MASK[i]) begin : g_cmp
            assign bit_ok[i] = (addr[i] == BASE[i]);
            assign offset[i] = 1'b0;
        end else begin : g_free
            assign bit_ok[i] = 1'b1;
            assign offset[i] = addr[i];
        end
    end

    assign hit = &bit_ok;

endmodule

// File: rtl/cmd_frame_seq.sv
module cmd_frame_seq
    import cmd_rx_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 2,
    parameter int DATA_BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [BYTE_W-1:0]            in_byte,
    input  logic                         in_stb,
    output logic                         frame_done,
    output logic [BYTE_W*ADDR_BYTES-1:0] frame_addr,
    output logic [BYTE_W*DATA_BYTES-1:0] frame_data
);

    localparam int FRAME_BYTES = ADDR_BYTES + DATA_BYTES;
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1);
    localparam int ADDR_W      = BYTE_W * ADDR_BYTES;
    localparam int DATA_W      = BYTE_W * DATA_BYTES;
    localparam int FRAME_W     = BYTE_W * FRAME_BYTES;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

    typedef struct packed {
        phase_e                               phase;
        logic [CNT_W-1:0]                     cnt;
        logic [FRAME_BYTES-1:0][BYTE_W-1:0]   slots;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       done_d;
    logic [FRAME_W-1:0] flat_d;

    always_comb begin
        s_d    = s_q;
        done_d = 1'b0;
        if (in_stb) begin
            s_d.phase    = PH_BUSY;
            s_d.cnt      = CNT_W'(1);
            s_d.slots[0] = in_byte;
        end else if (s_q.phase == PH_BUSY) begin
            s_d.slots[s_q.cnt] = in_byte;
            if (s_q.cnt == LAST_IDX) begin
                done_d    = 1'b1;
                s_d.phase = PH_IDLE;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, slots: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign flat_d     = s_d.slots;
    assign frame_done = done_d;
    assign frame_addr = flat_d[ADDR_W-1:0];
    assign frame_data = flat_d[ADDR_W +: DATA_W];

    // R7: a strobe always opens a fresh command at slot one
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        in_stb |=> (s_q.phase == PH_BUSY && s_q.cnt == CNT_W'(1)));

    // R8: unstrobed bytes never open a command
    assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_IDLE && !in_stb) |=> (s_q.phase == PH_IDLE));

    // R3: completion is never reported on two cycles in a row
    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

endmodule

// File: rtl/cmd_byte_rx.sv
module cmd_byte_rx #(
    parameter int          BYTE_W     = 8,
    parameter int          ADDR_BYTES = 2,
    parameter int          DATA_BYTES = 4,
    parameter int unsigned BASE_ADDR  = 32'h0000_0714,
    parameter int unsigned ADDR_MASK  = 32'h0000_07FF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [BYTE_W-1:0]            cmd_byte,
    input  logic                         cmd_stb,
    output logic                         wr_valid,
    output logic [BYTE_W*ADDR_BYTES-1:0] wr_offset,
    output logic [BYTE_W*DATA_BYTES-1:0] wr_data
);

    localparam int ADDR_W = BYTE_W * ADDR_BYTES;
    localparam int DATA_W = BYTE_W * DATA_BYTES;
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] MASK_V = ADDR_W'(ADDR_MASK);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] offset;
        logic [DATA_W-1:0] data;
    } wr_out_t;

    logic              frame_done;
    logic [ADDR_W-1:0] frame_addr;
    logic [DATA_W-1:0] frame_data;
    logic              addr_hit;
    logic [ADDR_W-1:0] addr_off;

    wr_out_t o_d, o_q;

    cmd_frame_seq #(
        .BYTE_W     (BYTE_W),
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_BYTES (DATA_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_byte    (cmd_byte),
        .in_stb     (cmd_stb),
        .frame_done (frame_done),
        .frame_addr (frame_addr),
        .frame_data (frame_data)
    );

    cmd_addr_match #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE_V),
        .MASK   (MASK_V)
    ) u_match (
        .addr   (frame_addr),
        .hit    (addr_hit),
        .offset (addr_off)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = 1'b0;
        if (frame_done && addr_hit) begin
            o_d.valid  = 1'b1;
            o_d.offset = addr_off;
            o_d.data   = frame_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign wr_valid  = o_q.valid;
    assign wr_offset = o_q.offset;
    assign wr_data   = o_q.data;

    // R3: the write pulse lasts one cycle
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R6: offsets never carry bits the mask compares
    assert_offset_free_R6: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ((wr_offset & MASK_V) == '0));

    // R9: outputs hold when no write is issued
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> ($stable(wr_data) && $stable(wr_offset)));

    // R4: a write is only issued after a completed frame
    assert_write_cause_R4: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> !wr_valid);

endmodule

// File: tb/cmd_byte_rx_tb.sv
module cmd_byte_rx_tb;

    localparam logic [15:0] MASK = 16'h07FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_byte = 8'h00;
    logic        cmd_stb = 1'b0;
    logic        wr_valid;
    logic [15:0] wr_offset;
    logic [31:0] wr_data;

    int total = 0;
    int fails = 0;
    int pulses = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cmd_byte_rx u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_byte  (cmd_byte),
        .cmd_stb   (cmd_stb),
        .wr_valid  (wr_valid),
        .wr_offset (wr_offset),
        .wr_data   (wr_data)
    );

    always @(negedge clk) if (wr_valid === 1'b1) pulses++;

    // {accept, address, data}
    localparam logic [48:0] VEC [0:5] = '{
        {1'b1, 16'h0714, 32'hDEADBEEF},
        {1'b1, 16'h1F14, 32'h00000001},
        {1'b0, 16'h0715, 32'h12345678},
        {1'b1, 16'h8714, 32'hA5C3E187},
        {1'b0, 16'h0614, 32'hFFFFFFFF},
        {1'b1, 16'hF714, 32'h80000000}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic put(input logic stb, input logic [7:0] b);
        @(negedge clk);
        cmd_stb  = stb;
        cmd_byte = b;
    endtask

    task automatic send_cmd(input logic [15:0] a, input logic [31:0] d);
        logic [47:0] f;
        f = {d, a};
        for (int i = 0; i < 6; i++) put(i == 0, f[i*8 +: 8]);
        put(1'b0, 8'h00);
    endtask

    initial begin
        logic [31:0] last_data;
        logic [15:0] last_off;
        int p0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, wr_valid}, 32'd0);
        chk("R1 data after reset", wr_data, 32'd0);
        chk("R1 offset after reset", {16'd0, wr_offset}, 32'd0);

        // R8: a matching byte pattern without strobe
        p0 = pulses;
        put(0, 8'h14); put(0, 8'h07);
        for (int i = 0; i < 4; i++) put(0, 8'h5A);
        put(0, 8'h00); put(0, 8'h00);
        chk("R8 no write without strobe", pulses - p0, 0);
        chk("R1 no open command after reset", wr_data, 32'd0);

        last_data = 32'd0;
        last_off  = 16'd0;
        for (int v = 0; v < 6; v++) begin
            logic        acc;
            logic [15:0] a;
            logic [31:0] d;
            {acc, a, d} = VEC[v];
            p0 = pulses;
            send_cmd(a, d);
            chk(acc ? "R4 R3 pulse on match" : "R5 no pulse on mismatch",
                {31'd0, wr_valid}, {31'd0, acc});
            if (acc) begin
                last_data = d;
                last_off  = a & ~MASK;
            end
            chk("R2 data assembly / R9 hold", wr_data, last_data);
            chk("R6 offset / R9 hold", {16'd0, wr_offset}, {16'd0, last_off});
            put(0, 8'h00);
            chk("R3 pulse is one cycle", {31'd0, wr_valid}, 32'd0);
            chk("R3 pulse count", pulses - p0, {31'd0, acc});
        end

        // R8: bytes trailing a completed command
        p0 = pulses;
        send_cmd(16'h0714, 32'h0BADF00D);
        for (int i = 0; i < 6; i++) put(0, (i == 0) ? 8'h14 : 8'h07);
        put(0, 8'h00);
        chk("R8 trailing bytes ignored", pulses - p0, 1);
        chk("R8 data after trailing bytes", wr_data, 32'h0BADF00D);
        last_data = 32'h0BADF00D;

        // R7: restart after three bytes
        p0 = pulses;
        put(1, 8'h14); put(0, 8'h07); put(0, 8'hAA);
        send_cmd(16'h0714, 32'h11223344);
        chk("R7 restart write", {31'd0, wr_valid}, 32'd1);
        chk("R7 restart data", wr_data, 32'h11223344);
        put(0, 8'h00);
        chk("R7 single pulse after restart", pulses - p0, 1);

        // R7: strobe takes the place of the sixth byte, new command mismatches
        p0 = pulses;
        put(1, 8'h14); put(0, 8'h07);
        for (int i = 0; i < 3; i++) put(0, 8'hEE);
        send_cmd(16'h0100, 32'hCAFEF00D);
        put(0, 8'h00);
        chk("R7 partial dropped at sixth slot", pulses - p0, 0);
        chk("R9 data held after drops", wr_data, 32'h11223344);

        // R10: reset in the middle of a command
        p0 = pulses;
        put(1, 8'h14); put(0, 8'h07); put(0, 8'h01); put(0, 8'h02);
        @(negedge clk); rst = 1'b1; cmd_stb = 1'b0; cmd_byte = 8'h03;
        @(negedge clk); rst = 1'b0; cmd_byte = 8'h04;
        put(0, 8'h05); put(0, 8'h06);
        put(0, 8'h00); put(0, 8'h00);
        chk("R10 no write after mid reset", pulses - p0, 0);
        chk("R10 data cleared", wr_data, 32'd0);
        send_cmd(16'h0714, 32'h76543210);
        chk("R10 recovers", wr_data, 32'h76543210);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog got=hung exp=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule